// File: doc/BRIEF.md
# Byte/Word Flag-Producing ALU

This block is a purely combinational arithmetic and logic unit for a small processor datapath. Each operation picks its own width: 8-bit (byte mode) or 16-bit (word mode). It covers several groups of operations:

- Addition, with and without an incoming carry.
- Subtraction, with and without an incoming borrow.
- Increment, decrement and two's-complement negation.
- Compare, which subtracts and keeps only the flags.
- Bitwise AND, OR, XOR and NOT.
- Test, which ANDs and keeps only the flags.

For every operation the unit returns a result and a write strobe for that result. It also returns six condition flags, and each flag has its own update bit. The surrounding core merges the flags into its status register, or simply takes the passed-through value.

Flag handling differs from one operation to the next. Increment and decrement never touch carry. Bitwise operations clear carry and overflow. Parity always looks at the low byte only. Compare and test produce flags but suppress the write. A flag that an operation leaves undefined is reported as not updated, and its output carries the incoming value.

Top module: `bw_flag_alu`

## Requirements
- R1: The opcode encoding is 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate, 7 compare, 8 AND, 9 OR, 10 XOR, 11 NOT, 12 test. Add returns A+B and add-with-carry returns A+B+CF, both truncated to the selected width. CF is set to the carry out of the top bit of that width.
- R2: Subtract returns A-B and subtract-with-borrow returns A-B-CF. Compare computes A-B for the flags only. In all three, CF is set when the true difference is negative (a borrow).
- R3: Increment returns A+1 and decrement returns A-1. Both update ZF, SF, OF, PF and AF, and both leave CF not updated.
- R4: Negate returns 0-A, updates all six flags, and sets CF exactly when A is nonzero.
- R5: The result write strobe is low for compare and test. It is high for every other defined opcode.
- R6: AND, OR, XOR and test set CF=0 and OF=0, and set ZF, SF and PF from the bitwise result. AF is reported as not updated.
- R7: NOT returns the bitwise inverse of A and updates no flag.
- R8: The flag rules are as follows. ZF means the width-masked result is zero. SF is the top bit of the selected width. OF is signed overflow at the selected width. AF is the carry or borrow across bit 3. PF is set when the low 8 result bits hold an even number of ones.
- R9: In byte mode, only the low 8 bits of A and B are used, and result bits 15:8 are zero.
- R10: The flag vectors use bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF. A flag whose update bit is clear is output equal to its incoming value.
- R11: Opcodes 13 to 15 produce result 0, a low write strobe and no flag updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation select (R1 encoding) |
| wordMode | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| flagsIn | input | 6 | Incoming flags (R10 layout) |
| result | output | 16 | Operation result |
| resultWe | output | 1 | Result should be written back |
| flagsOut | output | 6 | New flag values, passthrough where not updated |
| flagsUpd | output | 6 | Per-flag update indication |

## Verification
The bench targets the carry and borrow boundaries at both widths: 0xFF+1 against 0xFFFF+1, 0x00-1, and negation of zero and of the most negative value. A design that picks the carry out of the wrong bit, or forgets to invert it for subtraction, gets CF wrong at exactly these points. Overflow across the sign bit, such as 0x7F+1 in byte mode against 0x7FFF+1 in word mode, catches an overflow or sign taken from the wrong width. Parity on word results with busy high bytes catches parity computed over all 16 bits. Garbage in the upper operand byte during byte mode exposes operands that are not masked. Every flag-input pattern is run with every opcode, so a carry clobbered by increment, a missing write suppression on compare or test, or a non-updated flag that fails to pass through shows up as a mismatch on the ports.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_NEG  = 4'd6,
    OP_CMP  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_TEST = 4'd12
  } aluOp_e;

  localparam int FLAG_N = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;

  localparam logic [FLAG_N-1:0] MASK_ALL   = 6'h3F;
  localparam logic [FLAG_N-1:0] MASK_NO_CF = 6'h3E;
  localparam logic [FLAG_N-1:0] MASK_LOGIC = 6'h3B;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG,
    CIN_NFLAG
  } cinSel_e;

  typedef enum logic [2:0] {
    RES_SUM,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_NOT,
    RES_NONE
  } resSel_e;

  typedef struct packed {
    logic              subtract;
    logic              negate;
    logic              oneB;
    cinSel_e           cinSel;
    resSel_e           resSel;
    logic              writeEn;
    logic [FLAG_N-1:0] updMask;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opcode,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.cinSel   = CIN_ZERO;
    strobe.resSel   = RES_NONE;
    case (opcode)
      OP_ADD: begin
        strobe.resSel = RES_SUM; strobe.writeEn = 1'b1; strobe.updMask = MASK_ALL;
      end
      OP_ADC: begin
        strobe.resSel = RES_SUM; strobe.cinSel = CIN_FLAG;
        strobe.writeEn = 1'b1; strobe.updMask = MASK_ALL;
      end
      OP_SUB, OP_CMP: begin
        strobe.resSel = RES_SUM; strobe.subtract = 1'b1; strobe.cinSel = CIN_ONE;
        strobe.writeEn = (opcode == OP_SUB); strobe.updMask = MASK_ALL;
      end
      OP_SBB: begin
        strobe.resSel = RES_SUM; strobe.subtract = 1'b1; strobe.cinSel = CIN_NFLAG;
        strobe.writeEn = 1'b1; strobe.updMask = MASK_ALL;
      end
      OP_INC: begin
        strobe.resSel = RES_SUM; strobe.oneB = 1'b1;
        strobe.writeEn = 1'b1; strobe.updMask = MASK_NO_CF;
      end
      OP_DEC: begin
        strobe.resSel = RES_SUM; strobe.oneB = 1'b1; strobe.subtract = 1'b1;
        strobe.cinSel = CIN_ONE; strobe.writeEn = 1'b1; strobe.updMask = MASK_NO_CF;
      end
      OP_NEG: begin
        strobe.resSel = RES_SUM; strobe.negate = 1'b1; strobe.subtract = 1'b1;
        strobe.cinSel = CIN_ONE; strobe.writeEn = 1'b1; strobe.updMask = MASK_ALL;
      end
      OP_AND, OP_TEST: begin
        strobe.resSel = RES_AND; strobe.writeEn = (opcode == OP_AND);
        strobe.updMask = MASK_LOGIC;
      end
      OP_OR: begin
        strobe.resSel = RES_OR; strobe.writeEn = 1'b1; strobe.updMask = MASK_LOGIC;
      end
      OP_XOR: begin
        strobe.resSel = RES_XOR; strobe.writeEn = 1'b1; strobe.updMask = MASK_LOGIC;
      end
      OP_NOT: begin
        strobe.resSel = RES_NOT; strobe.writeEn = 1'b1;
      end
      default: begin
        strobe.resSel = RES_NONE;
      end
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  aluStrobe_t         strobe,
  input  logic               wordMode,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_N-1:0]  newFlags
);

  localparam int IDX_W  = $clog2(DATA_W + 1);
  localparam int HI_W   = DATA_W - NARROW_W;

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] aOp, bRaw, bEff;
  logic [DATA_W:0]   sum;
  logic              cin;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  carryIdx;
  logic              isLogic;
  logic              aTop, bTop, sTop;

  assign widthMask = wordMode ? {DATA_W{1'b1}} : {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
  assign topIdx    = wordMode ? IDX_W'(DATA_W - 1) : IDX_W'(NARROW_W - 1);
  assign carryIdx  = wordMode ? IDX_W'(DATA_W) : IDX_W'(NARROW_W);

  assign aOp  = strobe.negate ? '0 : (opA & widthMask);
  assign bRaw = strobe.negate ? opA : (strobe.oneB ? DATA_W'(1) : opB);
  assign bEff = (strobe.subtract ? ~bRaw : bRaw) & widthMask;

  always_comb begin
    case (strobe.cinSel)
      CIN_ONE:   cin = 1'b1;
      CIN_FLAG:  cin = carryIn;
      CIN_NFLAG: cin = ~carryIn;
      default:   cin = 1'b0;
    endcase
  end

  assign sum = {1'b0, aOp} + {1'b0, bEff} + (DATA_W + 1)'(cin);

  always_comb begin
    case (strobe.resSel)
      RES_SUM: result = sum[DATA_W-1:0] & widthMask;
      RES_AND: result = opA & opB & widthMask;
      RES_OR:  result = (opA | opB) & widthMask;
      RES_XOR: result = (opA ^ opB) & widthMask;
      RES_NOT: result = ~opA & widthMask;
      default: result = '0;
    endcase
  end

  assign isLogic = (strobe.resSel == RES_AND) || (strobe.resSel == RES_OR) ||
                   (strobe.resSel == RES_XOR);
  assign aTop = aOp[topIdx];
  assign bTop = bEff[topIdx];
  assign sTop = sum[topIdx];

  always_comb begin
    newFlags        = '0;
    newFlags[FL_ZF] = (result == '0);
    newFlags[FL_SF] = result[topIdx];
    newFlags[FL_PF] = ~^result[NARROW_W-1:0];
    if (!isLogic) begin
      newFlags[FL_CF] = sum[carryIdx] ^ strobe.subtract;
      newFlags[FL_OF] = (aTop == bTop) && (sTop != aTop);
      newFlags[FL_AF] = aOp[4] ^ bEff[4] ^ sum[4] ^ strobe.subtract;
    end
  end

endmodule

// File: rtl/bw_flag_alu.sv
module bw_flag_alu
  import alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [3:0]        opcode,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_N-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [FLAG_N-1:0] flagsOut,
  output logic [FLAG_N-1:0] flagsUpd
);

  localparam int HI_W = DATA_W - NARROW_W;

  aluStrobe_t        strobe;
  logic [FLAG_N-1:0] newFlags;

  alu_ctrl u_ctrl (
    .opcode (opcode),
    .strobe (strobe)
  );

  alu_datapath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .strobe   (strobe),
    .wordMode (wordMode),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (flagsIn[FL_CF]),
    .result   (result),
    .newFlags (newFlags)
  );

  assign resultWe = strobe.writeEn;
  assign flagsUpd = strobe.updMask;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flagMerge
    assign flagsOut[i] = strobe.updMask[i] ? newFlags[i] : flagsIn[i];
  end

  always_comb begin
    if (opcode == OP_INC || opcode == OP_DEC) begin
      assert_keep_carry_R3: assert (!flagsUpd[FL_CF] && flagsOut[FL_CF] == flagsIn[FL_CF])
        else $error("carry changed by increment/decrement");
    end
    if (opcode == OP_CMP || opcode == OP_TEST) begin
      assert_no_write_R5: assert (!resultWe) else $error("compare/test wrote result");
    end
    if (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR || opcode == OP_TEST) begin
      assert_logic_clear_R6: assert (!flagsOut[FL_CF] && !flagsOut[FL_OF])
        else $error("logic op left carry or overflow set");
    end
    if (opcode == OP_NOT) begin
      assert_not_flags_R7: assert (flagsUpd == '0 && flagsOut == flagsIn)
        else $error("NOT touched flags");
    end
    if (!wordMode) begin
      assert_upper_zero_R9: assert (result[DATA_W-1:NARROW_W] == HI_W'(0))
        else $error("byte mode upper result nonzero");
    end
    if (opcode > OP_TEST) begin
      assert_idle_op_R11: assert (!resultWe && flagsUpd == '0 && result == '0)
        else $error("unused opcode had an effect");
    end
  end

endmodule

// File: tb/bw_flag_alu_bench.sv
`timescale 1ns/1ps
module bw_flag_alu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode;
  logic        wordMode;
  logic [15:0] opA, opB;
  logic [5:0]  flagsIn;
  logic [15:0] result;
  logic        resultWe;
  logic [5:0]  flagsOut, flagsUpd;

  int checks = 0;
  int errors = 0;
  int printed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bw_flag_alu u_bw_flag_alu (
    .opcode   (opcode),
    .wordMode (wordMode),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .result   (result),
    .resultWe (resultWe),
    .flagsOut (flagsOut),
    .flagsUpd (flagsUpd)
  );

  function automatic string opTag(int op);
    case (op)
      0, 1:    return "R1";
      2, 3, 7: return "R2";
      4, 5:    return "R3";
      6:       return "R4";
      8, 9, 10, 12: return "R6";
      11:      return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic int sgn(int x, int w);
    return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
  endfunction

  task automatic model(input int op, input bit wm, input logic [15:0] A, input logic [15:0] B,
                       input logic [5:0] fin, output logic [15:0] r, output bit we,
                       output logic [5:0] fo, output logic [5:0] upd);
    int w = wm ? 16 : 8;
    int m = (1 << w) - 1;
    int a = int'(A) & m;
    int b = int'(B) & m;
    int c = int'(fin[0]);
    int smax = (1 << (w - 1)) - 1;
    int smin = -(1 << (w - 1));
    int res = 0;
    int sv = 0;
    bit cf = 0, af = 0, of = 0, ones;
    bit isArith = 0;
    int x = a, y = b, k = 0, isSub = 0;
    upd = 6'h00; we = 0;
    case (op)
      0: begin isArith = 1; k = 0; end
      1: begin isArith = 1; k = c; end
      2, 7: begin isArith = 1; isSub = 1; k = 0; end
      3: begin isArith = 1; isSub = 1; k = c; end
      4: begin isArith = 1; y = 1; k = 0; end
      5: begin isArith = 1; isSub = 1; y = 1; k = 0; end
      6: begin isArith = 1; isSub = 1; x = 0; y = a; k = 0; end
      8, 12: res = a & b;
      9: res = a | b;
      10: res = a ^ b;
      11: res = (~a) & m;
      default: res = 0;
    endcase
    if (isArith) begin
      if (isSub) begin
        res = x - y - k;
        cf  = (res < 0);
        af  = ((x & 15) - (y & 15) - k) < 0;
        sv  = sgn(x, w) - sgn(y, w) - k;
      end else begin
        res = x + y + k;
        cf  = (res > m);
        af  = ((x & 15) + (y & 15) + k) > 15;
        sv  = sgn(x, w) + sgn(y, w) + k;
      end
      of = (sv > smax) || (sv < smin);
    end
    r = 16'(res & m);
    ones = ^r[7:0];
    fo = fin;
    if (op <= 7 || op == 8 || op == 9 || op == 10 || op == 12) begin
      fo[3] = (r == 16'h0);
      fo[4] = r[w-1];
      fo[1] = ~ones;
      if (isArith) begin
        fo[5] = of; fo[2] = af;
        if (op != 4 && op != 5) fo[0] = cf;
        upd = (op == 4 || op == 5) ? 6'h3E : 6'h3F;
      end else begin
        fo[0] = 1'b0; fo[5] = 1'b0;
        upd = 6'h3B;
      end
    end
    we = (op <= 12) && (op != 7) && (op != 12);
  endtask

  task automatic fail(string tag, string what, int op, bit wm, logic [15:0] A,
                      logic [15:0] B, logic [5:0] fin, int act, int exp);
    errors++;
    if (printed < 30) begin
      printed++;
      $display("FAIL %s %s op=%0d word=%0d a=%h b=%h fin=%b actual=%h expected=%h",
               tag, what, op, wm, A, B, fin, act, exp);
    end
  endtask

  task automatic runVec(int op, bit wm, logic [15:0] A, logic [15:0] B, logic [5:0] fin);
    logic [15:0] er;
    bit ew;
    logic [5:0] efo, eupd;
    opcode = 4'(op); wordMode = wm; opA = A; opB = B; flagsIn = fin;
    #1;
    model(op, wm, A, B, fin, er, ew, efo, eupd);
    checks++;
    if (result !== er)
      fail(wm ? opTag(op) : "R9", "result", op, wm, A, B, fin, int'(result), int'(er));
    if (resultWe !== ew)
      fail(op == 7 || op == 12 ? "R5" : opTag(op), "we", op, wm, A, B, fin,
           int'(resultWe), int'(ew));
    if (flagsUpd !== eupd)
      fail(opTag(op), "upd", op, wm, A, B, fin, int'(flagsUpd), int'(eupd));
    for (int i = 0; i < 6; i++) begin
      if (flagsOut[i] !== efo[i])
        fail(eupd[i] ? "R8" : "R10", $sformatf("flag%0d", i), op, wm, A, B, fin,
             int'(flagsOut[i]), int'(efo[i]));
    end
    #1;
  endtask

  initial begin : watchdog
    #790us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] wv [11];
    logic [5:0]  fp [4];
    wv = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
           16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h0F0F};
    fp = '{6'h00, 6'h3F, 6'h15, 6'h2A};
    opcode = 4'd0; wordMode = 1'b0; opA = '0; opB = '0; flagsIn = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset-state check, R1: 0+0 gives zero with ZF and PF set
    runVec(0, 0, 16'h0, 16'h0, 6'h00);
    // Directed: R8 byte overflow 0x7F+1, R1 carry 0xFFFF+1, R4 negate of most negative
    runVec(0, 0, 16'h007F, 16'h0001, 6'h00);
    runVec(0, 1, 16'hFFFF, 16'h0001, 6'h00);
    runVec(6, 0, 16'h0080, 16'h0000, 6'h00);
    runVec(6, 1, 16'h0000, 16'h0000, 6'h3F);
    runVec(4, 0, 16'h00FF, 16'h0000, 6'h01);
    runVec(13, 1, 16'hFFFF, 16'hFFFF, 6'h2A);
    // Byte sweep: every A, 16 B values, all opcodes, four flag patterns; upper garbage for R9
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int op = 0; op < 16; op++) begin
          for (int f = 0; f < 4; f++) begin
            runVec(op, 0, {8'(a ^ 8'hA5), 8'(a)}, {8'(bi * 13 + 7), 8'(bi * 17)}, fp[f]);
          end
        end
      end
    end
    // Word sweep over boundary values
    for (int i = 0; i < 11; i++) begin
      for (int j = 0; j < 11; j++) begin
        for (int op = 0; op < 16; op++) begin
          for (int f = 0; f < 4; f++) begin
            runVec(op, 1, wv[i], wv[j], fp[f]);
          end
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule